// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel bidirectional buses, called side A and side B. Each transfer direction has its own holding register with its own clock. The register for the A-to-B direction samples side A, and the register for the B-to-A direction samples side B. Both registers sample on every rising edge of their clock, whatever the drive settings are. A bus can therefore be recorded while nothing is driven, and the recorded word can be replayed onto the other bus later.

An active-low drive-disable input and a direction input choose which side, if any, the block drives. For the side being driven, a per-side select input picks the source. Select low gives the live value of the opposite bus, passed through with no clock. Select high gives the content of the holding register that feeds that side.

Each bus appears as three vectors: an input vector, an output vector and a per-bit output-enable vector. Tri-state pads at the chip level combine them into a real bidirectional pin. The block has no streaming payload, so it carries no valid/ready handshake. All its pins are plain control and data pins.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On every rising edge of `clk_ab`, the A-to-B register loads `a_in`. This happens regardless of `oe_n`, `dir` and the select inputs.
- R2: On every rising edge of `clk_ba`, the B-to-A register loads `b_in`. This happens regardless of `oe_n`, `dir` and the select inputs.
- R3: While `oe_n` is 1, the block is isolated. `a_oe`, `b_oe`, `a_out` and `b_out` are all zero, and both registers still load on their clocks.
- R4: While `oe_n` is 0:
  - with `dir` = 0, `a_oe` is all ones and `b_oe` is all zeros;
  - with `dir` = 1, `b_oe` is all ones and `a_oe` is all zeros.
- R5: While side A is driven:
  - with `sel_a` = 0, `a_out` equals `b_in` combinationally;
  - with `sel_a` = 1, `a_out` equals the B-to-A register.
- R6: While side B is driven:
  - with `sel_b` = 0, `b_out` equals `a_in` combinationally;
  - with `sel_b` = 1, `b_out` equals the A-to-B register.
- R7: `a_oe` and `b_oe` are never both non-zero.
- R8: A stored-path output changes only at the rising edge of the clock of its register. A change on the bus input with no edge leaves the output unchanged.
- R9: `rst_n` = 0 clears both registers to zero at once, without any clock edge.
- R10: A vector that is not driven outputs zero. The select input of the undriven side has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_ab | input | 1 | Sampling clock of the A-to-B register |
| clk_ba | input | 1 | Sampling clock of the B-to-A register |
| oe_n | input | 1 | Active-low drive enable; high isolates both sides |
| dir | input | 1 | 0 drives side A, 1 drives side B |
| sel_a | input | 1 | Source for side A: 0 live B, 1 stored B-to-A |
| sel_b | input | 1 | Source for side B: 0 live A, 1 stored A-to-B |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value driven onto bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value driven onto bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
The hardest situation to reach is one where stored data and live data differ at the moment of replay. Without that, a design that skips the register would give the same output. The bench captures both buses while the block is isolated, then changes both bus inputs with no clock edge, and only then enables a side with its select high. Any output that follows the live value is then detected. The sweep covers every pairing of drive mode and selects, with the register clocks pulsed or withheld according to the pattern index. This exposes both capture while driving and the absence of capture when no edge occurs.

// File: rtl/dual_reg_xcvr_pkg.sv
package dual_reg_xcvr_pkg;
  // which side of the transceiver currently owns its bus
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_TO_A = 2'd1,
    ROUTE_TO_B = 2'd2
  } route_e;
endpackage

// File: rtl/drx_hold_reg.sv
module drx_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // samples on every edge: capture is never qualified by drive state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/drx_route_ctl.sv
module drx_route_ctl
  import dual_reg_xcvr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output route_e route
);
  always_comb begin
    if (oe_n)     route = ROUTE_NONE;
    else if (dir) route = ROUTE_TO_B;
    else          route = ROUTE_TO_A;
  end
endmodule

// File: rtl/drx_side_mux.sv
module drx_side_mux
  import dual_reg_xcvr_pkg::*;
#(
  parameter int     W    = 8,
  parameter route_e SIDE = ROUTE_TO_A
) (
  input  route_e       route,
  input  logic         sel_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out,
  output logic [W-1:0] oe
);
  logic         active;
  logic [W-1:0] pick;

  assign active = (route == SIDE);
  assign pick   = sel_stored ? stored : live;

  // undriven side presents zero so idle pads see a defined value
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign oe[i]  = active;
    assign out[i] = active & pick[i];
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import dual_reg_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_a,
  input  logic         sel_b,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic [W-1:0] q_ab;
  logic [W-1:0] q_ba;
  route_e       route;

  drx_hold_reg #(.W(W)) u_reg_ab (
    .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(q_ab)
  );

  drx_hold_reg #(.W(W)) u_reg_ba (
    .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(q_ba)
  );

  drx_route_ctl u_route (
    .oe_n(oe_n), .dir(dir), .route(route)
  );

  drx_side_mux #(.W(W), .SIDE(ROUTE_TO_A)) u_side_a (
    .route(route), .sel_stored(sel_a), .live(b_in), .stored(q_ba),
    .out(a_out), .oe(a_oe)
  );

  drx_side_mux #(.W(W), .SIDE(ROUTE_TO_B)) u_side_b (
    .route(route), .sel_stored(sel_b), .live(a_in), .stored(q_ab),
    .out(b_out), .oe(b_oe)
  );
endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_a,
  input logic         sel_b,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] q_ab,
  input logic [W-1:0] q_ba
);
  assert_capture_ab_R1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    rst_n |=> (q_ab == $past(a_in)));

  assert_capture_ba_R2: assert property (@(posedge clk_ba) disable iff (!rst_n)
    rst_n |=> (q_ba == $past(b_in)));

  assert_isolate_R3: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

  assert_dir_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !oe_n |-> (dir ? (b_oe == '1 && a_oe == '0) : (a_oe == '1 && b_oe == '0)));

  assert_side_a_R5: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && !dir) |-> (a_out == (sel_a ? q_ba : b_in)));

  assert_side_b_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir) |-> (b_out == (sel_b ? q_ab : a_in)));

  assert_exclusive_R7: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));
endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.W(W)) u_chk (
  .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
  .sel_a(sel_a), .sel_b(sel_b), .a_in(a_in), .b_in(b_in), .a_out(a_out),
  .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe), .q_ab(q_ab), .q_ba(q_ba)
);

// File: tb/tb_dual_reg_xcvr.sv
module tb_dual_reg_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz frame clock

  logic         rst_n, clk_ab, clk_ba, oe_n, dir, sel_a, sel_b;
  logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;

  dual_reg_xcvr #(.W(W)) dut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_a(sel_a), .sel_b(sel_b), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_ab = '0;
  logic [W-1:0] m_ba = '0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // set inputs, optionally pulse the register clocks, let outputs settle
  task automatic step(input logic on, input logic d, input logic sa, input logic sb,
                      input logic [W-1:0] av, input logic [W-1:0] bv,
                      input logic pa, input logic pb);
    @(negedge clk);
    oe_n = on; dir = d; sel_a = sa; sel_b = sb; a_in = av; b_in = bv;
    #3;
    if (pa) begin clk_ab = 1'b1; m_ab = av; end
    if (pb) begin clk_ba = 1'b1; m_ba = bv; end
    #3;
    clk_ab = 1'b0; clk_ba = 1'b0;
    #2;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [W-1:0] ea, eb, eoa, eob;
    rst_n = 1'b0; clk_ab = 0; clk_ba = 0; oe_n = 1; dir = 0;
    sel_a = 0; sel_b = 0; a_in = '0; b_in = '0;
    repeat (2) @(posedge clk);
    // R9 reset state: stored paths replay zero while reset is held
    step(0, 0, 1, 0, 8'hFF, 8'hEE, 0, 0);
    chk("R9 reset a_out", a_out, '0);
    step(0, 1, 0, 1, 8'hFF, 8'hEE, 0, 0);
    chk("R9 reset b_out", b_out, '0);
    rst_n = 1'b1;

    // sweep of drive modes, selects and clock pulses
    for (int mode = 0; mode < 3; mode++) begin
      for (int s = 0; s < 4; s++) begin
        for (int p = 0; p < 8; p++) begin
          logic on, d, sa, sb;
          logic [W-1:0] av, bv;
          on = (mode == 2); d = (mode == 1); sa = s[0]; sb = s[1];
          av = W'(p * 37 + 5 + s * 11); bv = W'(p * 91 + 200 + mode * 3);
          step(on, d, sa, sb, av, bv, p[0], p[1]);
          eoa = (!on && !d) ? '1 : '0;
          eob = (!on && d)  ? '1 : '0;
          ea  = eoa & (sa ? m_ba : bv);
          eb  = eob & (sb ? m_ab : av);
          chk(on ? "R3 a_oe" : "R4 a_oe", a_oe, eoa);
          chk(on ? "R3 b_oe" : "R4 b_oe", b_oe, eob);
          chk(on ? "R3 a_out" : (d ? "R10 a_out" : "R5 a_out"), a_out, ea);
          chk(on ? "R3 b_out" : (d ? "R6 b_out" : "R10 b_out"), b_out, eb);
          chk("R7 exclusive", W'((|a_oe) && (|b_oe)), '0);
        end
      end
    end

    // capture while isolated, change buses, then replay
    step(1, 0, 0, 0, 8'h11, 8'h22, 1, 1);
    chk("R3 isolated a_oe", a_oe, '0);
    chk("R3 isolated b_oe", b_oe, '0);
    step(1, 0, 0, 0, 8'h99, 8'h77, 0, 0);
    step(0, 1, 0, 1, 8'h99, 8'h77, 0, 0);
    chk("R1 replay stored A", b_out, 8'h11);
    step(0, 0, 1, 0, 8'h99, 8'h77, 0, 0);
    chk("R2 replay stored B", a_out, 8'h22);

    // capture on side A while side B is driven live
    step(0, 1, 0, 0, 8'h5A, 8'h33, 1, 0);
    chk("R6 live while capturing", b_out, 8'h5A);
    step(0, 1, 0, 1, 8'h00, 8'h33, 0, 0);
    chk("R1 capture while driven", b_out, 8'h5A);

    // stored output waits for its clock edge
    step(0, 0, 1, 0, 8'h00, 8'h3C, 0, 1);
    chk("R8 after edge", a_out, 8'h3C);
    step(0, 0, 1, 0, 8'h00, 8'hA5, 0, 0);
    chk("R8 no edge holds", a_out, 8'h3C);
    step(0, 0, 1, 0, 8'h00, 8'hA5, 0, 1);
    chk("R8 next edge", a_out, 8'hA5);

    // asynchronous clear with no clock edge
    #1 rst_n = 1'b0; #1;
    chk("R9 async clear a_out", a_out, '0);
    m_ab = '0; m_ba = '0;
    rst_n = 1'b1;
    step(0, 1, 0, 1, 8'h44, 8'h55, 0, 0);
    chk("R9 cleared A-to-B", b_out, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule